// File: doc/BRIEF.md
# Paged Address Translator with TLB Refill

This block sits between a CPU and memory and turns each 32-bit virtual address into a physical address. The upper 20 bits are the page number and the low 12 bits are the byte offset. A small fully associative translation buffer holds recent page-table entries. Each line is tagged by page number and keeps a frame number, a write-permission flag and a valid flag. When a lookup finds no matching line, a two-state controller takes the shared memory port. It reads the entry for that page from a flat table in memory and loads it into a line chosen in round-robin order. The controller then repeats the lookup. The CPU is held with its ready signal low until that repeated lookup either succeeds or faults.

Software configures the block through three writable registers: an enable flag, the table base address and the table length. Faults are reported on a trap request output. A status word records the faulting page and the kind of fault. While translation is disabled, addresses pass straight through.

Top module: `pagedXlate`

## Requirements
- R1: With translation disabled, `physAddr` equals `cpuVaddr`, `cpuReady` follows `cpuReq` in the same cycle, and `trapReq` stays low.
- R2: A request whose page is held in a buffer line completes in the same cycle. `physAddr` is the cached frame number followed by the unchanged 12-bit offset, and no memory request is made.
- R3: A request whose page is not buffered keeps `cpuReady` low. It raises `memReq` with `memAddr` = table base + page number, held until `memAck`. The entry is loaded at the acknowledging edge, and the repeated lookup resolves in the next cycle.
- R4: A table entry carries the frame number in bits 31:12, the write-permission flag in bit 1 and the valid flag in bit 0.
- R5: An entry with its valid flag clear faults. `trapReq` is asserted with `cpuReady`, and the status word gets its invalid-address bit set.
- R6: A write to a page whose write-permission flag is clear faults with the illegal-operation bit set. A read of the same page translates normally.
- R7: A page number greater than or equal to the length register faults as an invalid address, with no memory request.
- R8: The status word holds the faulting page in bits 31:12, illegal-operation in bit 1 and invalid-address in bit 0. It is loaded at the clock edge that ends a faulting request and is unchanged by every other request.
- R9: Refills fill the buffer lines in round-robin order. After LINES distinct refills, the next refill evicts the earliest-loaded page.
- R10: Writing the enable register or the table-base register empties every buffer line, so the next access to any page refills it.
- R11: After reset, translation is off, the table base and length are zero, the status word is zero, and `memReq` and `trapReq` are low.
- R12: Register writes use `regSel` 0 for the enable flag (data bit 0), 1 for the table base and 2 for the table length (data bits 20:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU access request, held until ready |
| cpuWrite | input | 1 | Access is a write |
| cpuVaddr | input | 32 | Virtual address |
| cpuReady | output | 1 | Access completes this cycle |
| physAddr | output | 32 | Translated physical address |
| trapReq | output | 1 | Fault on the completing access |
| regWrEn | input | 1 | Configuration register write strobe |
| regSel | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| statusWord | output | 32 | Fault status word |
| memReq | output | 1 | Table fetch request on the memory port |
| memAddr | output | 32 | Table entry address |
| memAck | input | 1 | Memory read complete |
| memData | input | 32 | Table entry read data |

## Verification
The bench builds the block with LINES set to 4 and all widths at their defaults. With only four lines, random traffic over fourteen pages cycles through round-robin eviction often and reaches the case where a newly refilled page overwrites one still in use. The table length is moved at random between 4 and 12, so the bound comparison is exercised on both sides, including a page exactly equal to the limit. Memory latency varies from zero to three wait cycles, which exercises the refill handshake from an immediate acknowledge up to a long stall.

// File: rtl/xlatePkg.sv
package xlatePkg;
  typedef enum logic {XLATE, WALK} stateT;

  // lookup outcome from datapath to control
  typedef struct packed {
    logic passThru;
    logic hit;
    logic fault;
  } lookT;

  // strobes from control to datapath
  typedef struct packed {
    logic walk;
    logic fill;
    logic capture;
  } strobeT;
endpackage

// File: rtl/xlateDatapath.sv
module xlateDatapath
  import xlatePkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrite,
  input  logic [VA_W-1:0]   cpuVaddr,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic [PA_W-1:0]   memData,
  input  strobeT            stb,
  output lookT              look,
  output logic [PA_W-1:0]   physAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [VA_W-1:0]   statusWord
);
  localparam int PAGE_W  = VA_W - OFF_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int IDX_W   = $clog2(LINES);

  logic                ctlOn;
  logic [ADDR_W-1:0]   ptrReg;
  logic [PAGE_W:0]     maxReg;
  logic [VA_W-1:0]     statusReg;
  logic [IDX_W-1:0]    rrIdx;
  logic [LINES-1:0]    lineUsed;
  logic [PAGE_W-1:0]   lineTag   [LINES];
  logic [FRAME_W-1:0]  lineFrame [LINES];
  logic [LINES-1:0]    lineW;
  logic [LINES-1:0]    lineV;

  logic [PAGE_W-1:0]   page;
  logic [OFF_W-1:0]    offset;
  logic [LINES-1:0]    hitVec;
  logic                anyHit, inBounds, selW, selV, faultInv, faultIll, cfgTouch;
  logic [FRAME_W-1:0]  selFrame;

  assign page     = cpuVaddr[VA_W-1:OFF_W];
  assign offset   = cpuVaddr[OFF_W-1:0];
  assign inBounds = {1'b0, page} < maxReg;
  assign cfgTouch = regWrEn && (regSel == 2'd0 || regSel == 2'd1);

  for (genvar i = 0; i < LINES; i++) begin : gHit
    assign hitVec[i] = lineUsed[i] && (lineTag[i] == page);
  end

  always_comb begin
    selFrame = '0;
    selW     = 1'b0;
    selV     = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (hitVec[i]) begin
        selFrame = selFrame | lineFrame[i];
        selW     = selW | lineW[i];
        selV     = selV | lineV[i];
      end
    end
  end

  assign anyHit   = |hitVec;
  assign faultInv = !inBounds || (anyHit && !selV);
  assign faultIll = inBounds && anyHit && selV && cpuWrite && !selW;

  assign look.passThru = !ctlOn;
  assign look.fault    = faultInv || faultIll;
  assign look.hit      = inBounds && anyHit && selV && !(cpuWrite && !selW);

  assign physAddr   = ctlOn ? {selFrame, offset} : PA_W'(cpuVaddr);
  assign memAddr    = ptrReg + ADDR_W'(page);
  assign statusWord = statusReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlOn     <= 1'b0;
      ptrReg    <= '0;
      maxReg    <= '0;
      statusReg <= '0;
    end else begin
      if (regWrEn) begin
        case (regSel)
          2'd0:    ctlOn  <= regWrData[0];
          2'd1:    ptrReg <= regWrData;
          2'd2:    maxReg <= regWrData[PAGE_W:0];
          default: ;
        endcase
      end
      if (stb.capture)
        statusReg <= {page, {(OFF_W-2){1'b0}}, faultIll, faultInv};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineUsed <= '0;
      rrIdx    <= '0;
    end else begin
      if (cfgTouch)
        lineUsed <= '0;
      else if (stb.fill)
        lineUsed[rrIdx] <= 1'b1;
      if (stb.fill)
        rrIdx <= (rrIdx == IDX_W'(LINES-1)) ? '0 : rrIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fill) begin
      lineTag[rrIdx]   <= page;
      lineFrame[rrIdx] <= memData[PA_W-1:OFF_W];
      lineW[rrIdx]     <= memData[1];
      lineV[rrIdx]     <= memData[0];
    end
  end

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec)); // R9
  AST_CAPTURE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> ($countones(statusReg[1:0]) == 1)); // R8
endmodule

// File: rtl/xlateControl.sv
module xlateControl
  import xlatePkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cpuReq,
  input  logic   memAck,
  input  lookT   look,
  output strobeT stb,
  output logic   cpuReady,
  output logic   trapReq,
  output logic   memReq
);
  stateT state, stateNext;
  logic  grant, miss;

  assign grant    = (state == XLATE) && cpuReq;
  assign miss     = grant && !look.passThru && !look.hit && !look.fault;
  assign cpuReady = grant && (look.passThru || look.hit || look.fault);
  assign trapReq  = grant && !look.passThru && look.fault;

  assign stb.walk    = (state == WALK);
  assign stb.fill    = (state == WALK) && memAck;
  assign stb.capture = trapReq;
  assign memReq      = stb.walk;

  always_comb begin
    stateNext = state;
    case (state)
      XLATE:   if (miss) stateNext = WALK;
      WALK:    if (memAck) stateNext = XLATE;
      default: stateNext = XLATE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= XLATE;
    else       state <= stateNext;
  end

  AST_STALL_IN_WALK: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady); // R3
  AST_RETRY_RESOLVES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.fill) && cpuReq && !look.passThru) |-> (look.hit || look.fault)); // R3
endmodule

// File: rtl/pagedXlate.sv
module pagedXlate
  import xlatePkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [VA_W-1:0]   cpuVaddr,
  output logic              cpuReady,
  output logic [PA_W-1:0]   physAddr,
  output logic              trapReq,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [VA_W-1:0]   statusWord,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [PA_W-1:0]   memData
);
  lookT   look;
  strobeT stb;

  xlateDatapath #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .LINES(LINES)
  ) dp (
    .clk(clk), .rstN(rstN), .cpuWrite(cpuWrite), .cpuVaddr(cpuVaddr),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .memData(memData), .stb(stb), .look(look), .physAddr(physAddr),
    .memAddr(memAddr), .statusWord(statusWord)
  );

  xlateControl ctl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .memAck(memAck), .look(look),
    .stb(stb), .cpuReady(cpuReady), .trapReq(trapReq), .memReq(memReq)
  );

  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && look.passThru) |-> (!trapReq && cpuReady && physAddr == PA_W'(cpuVaddr))); // R1
  AST_TRAP_COMPLETES: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (cpuReady && !memReq)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !regWrEn) |=> (memReq && $stable(memAddr))); // R3
endmodule

// File: tb/pagedXlate_test.sv
`timescale 1ns/1ps
module pagedXlate_test;
  localparam int LINES = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [31:0] cpuVaddr = '0;
  logic        cpuReady, trapReq, memReq;
  logic [31:0] physAddr, statusWord, memAddr;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [31:0] regWrData = '0;
  logic        memAck = 1'b0;
  logic [31:0] memData = '0;

  int checks = 0, errors = 0, fetches = 0, cyc = 0, memDelay = 0;

  logic [31:0] mPtr = '0;
  logic [20:0] mMax = '0;
  bit          mOn = 1'b0;
  logic [19:0] mTag [LINES];
  bit          mUsed [LINES];
  int          mRr = 0;
  logic [31:0] mStatus = '0;

  pagedXlate #(.LINES(LINES)) uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuVaddr(cpuVaddr), .cpuReady(cpuReady), .physAddr(physAddr),
    .trapReq(trapReq), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .statusWord(statusWord), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memData(memData)
  );

  always #4 clk = ~clk;

  // table contents (R4 format): frame in 31:12, write flag bit 1, valid bit 0
  function automatic logic [31:0] pteOf(logic [19:0] p);
    logic [19:0] f;
    f = p * 20'd7 + 20'h3A;
    return {f, 10'b0, p[0], (p % 20'd3) != 20'd2};
  endfunction

  task automatic checkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(negedge clk) begin
    if (memReq && !memAck) begin
      if (memDelay == 0) begin
        memAck = 1'b1;
        memData = pteOf(20'(memAddr - mPtr));
        memDelay = $urandom_range(0, 3);
      end else memDelay--;
    end else memAck = 1'b0;
  end

  always @(posedge clk) begin
    if (memReq && memAck) fetches++;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  function automatic bit modelHit(logic [19:0] p);
    for (int i = 0; i < LINES; i++) if (mUsed[i] && mTag[i] == p) return 1'b1;
    return 1'b0;
  endfunction

  task automatic modelFlush();
    for (int i = 0; i < LINES; i++) mUsed[i] = 1'b0;
  endtask

  task automatic regWrite(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
    case (sel) // R12
      2'd0: begin mOn = data[0]; modelFlush(); end   // R10
      2'd1: begin mPtr = data; modelFlush(); end     // R10
      2'd2: mMax = data[20:0];
      default: ;
    endcase
  endtask

  task automatic access(logic [31:0] va, bit wr);
    logic [19:0] pg;
    logic [31:0] e, expPhys, gotPhys;
    bit expMiss, expTrap, expIll, expInv, gotTrap, addrSeen;
    int f0, waitCyc;
    pg = va[31:12];
    expMiss = 0; expTrap = 0; expIll = 0; expInv = 0; expPhys = va;
    if (mOn) begin
      if ({1'b0, pg} >= mMax) begin
        expTrap = 1; expInv = 1;
      end else begin
        expMiss = !modelHit(pg);
        e = pteOf(pg);
        if (!e[0]) begin expTrap = 1; expInv = 1; end
        else if (wr && !e[1]) begin expTrap = 1; expIll = 1; end
        else expPhys = {e[31:12], va[11:0]};
      end
    end
    f0 = fetches; waitCyc = 0; addrSeen = 0;
    @(negedge clk);
    cpuReq = 1'b1; cpuVaddr = va; cpuWrite = wr;
    #1;
    while (!cpuReady && waitCyc < 60) begin
      if (memReq && !addrSeen) begin
        checkEq("R3", "table entry address", memAddr, mPtr + 32'(pg));
        addrSeen = 1;
      end
      @(negedge clk); #1;
      waitCyc++;
    end
    gotTrap = trapReq; gotPhys = physAddr;
    if (!cpuReady) begin
      errors++; checks++;
      $display("FAIL R3 access never completed: actual 0 expected 1");
    end
    @(negedge clk);
    cpuReq = 1'b0; cpuWrite = 1'b0;
    checkEq("R3", "table fetches", 32'(fetches - f0), 32'(expMiss));
    checkEq(expMiss ? "R3" : "R2", "stall seen", 32'(waitCyc >= 2), 32'(expMiss));
    checkEq(expIll ? "R6" : (expInv ? "R5" : "R1"), "trap", 32'(gotTrap), 32'(expTrap));
    if (expTrap) mStatus = {pg, 10'b0, expIll, expInv};
    else checkEq(mOn ? "R2" : "R1", "physical address", gotPhys, expPhys);
    checkEq("R8", "status word", statusWord, mStatus);
    if (expMiss) begin // R9 round-robin fill
      mTag[mRr] = pg; mUsed[mRr] = 1'b1; mRr = (mRr + 1) % LINES;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    modelFlush();
    repeat (5) @(negedge clk);
    #1;
    checkEq("R11", "ready in reset", 32'(cpuReady), 0);
    checkEq("R11", "memReq in reset", 32'(memReq), 0);
    checkEq("R11", "trap in reset", 32'(trapReq), 0);
    checkEq("R11", "status in reset", statusWord, 0);
    rstN = 1'b1;
    // R11 + R1: translation off after reset
    access(32'h0001_2345, 1'b1);
    regWrite(2'd2, 32'd8);
    regWrite(2'd1, 32'h0000_4000);
    regWrite(2'd0, 32'd1);
    access(32'h0000_1ABC, 1'b0); // R3 miss
    access(32'h0000_1ABC, 1'b1); // R2 hit, write allowed
    access(32'h0000_2004, 1'b0); // R5 invalid entry
    access(32'h0000_0FF0, 1'b1); // R6 read-only page
    access(32'h0000_0FF0, 1'b0); // R6 read allowed
    access(32'h0000_8000, 1'b0); // R7 page == length
    access(32'h0000_7010, 1'b1); // R7 last legal page
    // R9 eviction: five distinct refills into four lines
    regWrite(2'd1, 32'h0000_4000);
    access(32'h0000_0000, 1'b0);
    access(32'h0000_1000, 1'b0);
    access(32'h0000_3000, 1'b0);
    access(32'h0000_4000, 1'b0);
    access(32'h0000_6000, 1'b0);
    access(32'h0000_1000, 1'b0); // still held
    access(32'h0000_0000, 1'b0); // evicted, refills
    // R10: rewriting control empties lines
    access(32'h0000_6000, 1'b0);
    regWrite(2'd0, 32'd1);
    access(32'h0000_6000, 1'b0);
    regWrite(2'd0, 32'd0);
    access(32'h00AB_CDEF, 1'b1); // R1
    regWrite(2'd0, 32'd1);
    for (int n = 0; n < 500; n++) begin
      int r;
      r = $urandom_range(0, 24);
      if (r == 0) regWrite(2'd0, 32'($urandom_range(0, 3) != 0));
      else if (r == 1) regWrite(2'd1, 32'h0000_4000 + (32'($urandom_range(0, 3)) << 8));
      else if (r == 2) regWrite(2'd2, 32'($urandom_range(4, 12)));
      else access({20'($urandom_range(0, 13)), 12'($urandom)}, 1'($urandom_range(0, 1)));
    end
    summary();
    $finish;
  end
endmodule